// File: doc/BRIEF.md
# Dual-Bank Modular Operand Datapath

This block holds working operands for a modular-arithmetic engine in two equal storage banks. A small arithmetic unit sits between them. An external sequencer drives it one micro-operation at a time. The set covers load, store, move, compare-to-zero, and a calculate step that adds, subtracts or multiplies modulo a small prime.

A calculate step always takes both of its operands from one bank and writes its result into the other bank. Values therefore ping-pong between the banks as a computation proceeds. When a result is needed on the same side as its inputs, the sequencer must issue an explicit move. Constants are expected to be loaded into both banks at the same slot before computation starts.

Add, subtract, move, load, store and compare finish one cycle after issue. Multiply is a bit-serial shift-and-add loop of `W` steps. While any operation is in flight, `busy` is high. A micro-op issued while `busy` is high is dropped and flagged on `err`.

Top module: `dual_bank_datapath`

## Requirements
- R1: After reset `busy`, `zero_flag`, `err` and `rdata_valid` are all low.
- R2: A calc step (kind code 5) reads slots `src_a` and `src_b` from bank `src_bank` and writes slot `dst_slot` of the opposite bank. It ignores `dst_bank` and leaves slot `dst_slot` of the source bank unchanged.
- R3: Operation code 0 (add) yields (a+b) mod p, fully reduced into [0, p-1].
- R4: Operation code 1 (subtract) yields a-b, with p added back when the raw difference is negative.
- R5: Operation code 2 (multiply) yields (a*b) mod p. `busy` stays high until the product has been written.
- R6: A move (kind code 3) copies slot `src_a` of bank `src_bank` unchanged into slot `dst_slot` of bank `dst_bank`.
- R7: A compare (kind code 4) sets `zero_flag` to 1 exactly when slot `src_a` of bank `src_bank` holds 0. The flag keeps its value until the next compare.
- R8: A load (kind code 1) writes `ext_wdata` into slot `dst_slot` of bank `dst_bank`. A store (kind code 2) drives slot `src_a` of bank `src_bank` onto `ext_rdata` with a one-cycle `rdata_valid` pulse.
- R9: A micro-op presented while `busy` is high is ignored and causes a one-cycle `err` pulse.
- R10: A value written by one micro-op is visible to the micro-op issued right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uop_valid | input | 1 | Micro-op present this cycle |
| uop_kind | input | 3 | 0 nop, 1 load, 2 store, 3 move, 4 compare, 5 calc |
| alu_op | input | 2 | 0 add, 1 subtract, 2 multiply |
| src_bank | input | 1 | Bank read by calc, move, store, compare |
| src_a | input | 5 | First source slot |
| src_b | input | 5 | Second source slot (calc only) |
| dst_bank | input | 1 | Bank written by load and move |
| dst_slot | input | 5 | Destination slot |
| ext_wdata | input | W | Load data |
| ext_rdata | output | W | Store data |
| rdata_valid | output | 1 | Store data valid pulse |
| busy | output | 1 | Micro-op in flight |
| zero_flag | output | 1 | Result of the last compare |
| err | output | 1 | Issue-while-busy pulse |

## Verification
The bench goes after the reduction edges: sums that land exactly on p, and differences that go negative or reach zero. An adder without the final subtraction of p would return p or values above it, and a subtracter without the add-back would return wrapped values. It also writes a calc's result with `dst_bank` naming the source bank and reads back both banks. A design that honoured that field would overwrite the sentinel in the source bank. Finally it issues a load in the middle of a multiply. If that load were accepted it would corrupt the target slot, and if it were silently dropped no `err` pulse would appear.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_MOVE  = 3'd3,
        K_CMPZ  = 3'd4,
        K_CALC  = 3'd5
    } uop_kind_e;

    typedef enum logic [1:0] {
        A_ADD = 2'd0,
        A_SUB = 2'd1,
        A_MUL = 2'd2
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_MUL  = 2'd2
    } ctl_state_e;

    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/dbk_bank.sv
module dbk_bank #(
    parameter int W  = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_a <= mem[raddr_a];
        rdata_b <= mem[raddr_b];
    end
endmodule

// File: rtl/dbk_addsub.sv
module dbk_addsub #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   MODULUS = W'(251)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] r
);
    logic [W:0] sum;
    logic [W:0] diff;
    logic [W:0] sum_red;
    logic [W:0] diff_fix;

    always_comb begin
        sum      = {1'b0, a} + {1'b0, b};
        diff     = {1'b0, a} - {1'b0, b};
        sum_red  = sum - {1'b0, MODULUS};
        diff_fix = diff + {1'b0, MODULUS};
        if (sub)
            r = diff[W] ? diff_fix[W-1:0] : diff[W-1:0];
        else
            r = (sum >= {1'b0, MODULUS}) ? sum_red[W-1:0] : sum[W-1:0];
    end
endmodule

// File: rtl/dbk_mulseq.sv
module dbk_mulseq #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   MODULUS = W'(251)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc, ma, mb;
    logic [CW-1:0] cnt;
    logic          active;
    logic [W-1:0]  dbl, plus;

    dbk_addsub #(.W(W), .MODULUS(MODULUS)) u_dbl (
        .a(acc), .b(acc), .sub(1'b0), .r(dbl)
    );
    dbk_addsub #(.W(W), .MODULUS(MODULUS)) u_plus (
        .a(dbl), .b(ma), .sub(1'b0), .r(plus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            acc    <= '0;
            ma     <= '0;
            mb     <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(W);
            acc    <= '0;
            ma     <= a;
            mb     <= b;
        end else if (active) begin
            if (cnt != '0) begin
                acc <= mb[W-1] ? plus : dbl;
                mb  <= mb << 1;
                cnt <= cnt - 1'b1;
            end else begin
                active <= 1'b0;
            end
        end
    end

    assign done = active && (cnt == '0);
    assign res  = acc;
endmodule

// File: rtl/dual_bank_datapath.sv
module dual_bank_datapath
    import dbk_pkg::*;
#(
    parameter int             W       = 8,
    parameter int             AW      = 5,
    parameter logic [W-1:0]   MODULUS = W'(251)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          uop_valid,
    input  logic [2:0]    uop_kind,
    input  logic [1:0]    alu_op,
    input  logic          src_bank,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic          dst_bank,
    input  logic [AW-1:0] dst_slot,
    input  logic [W-1:0]  ext_wdata,
    output logic [W-1:0]  ext_rdata,
    output logic          rdata_valid,
    output logic          busy,
    output logic          zero_flag,
    output logic          err
);
    ctl_state_e    state;
    uop_kind_e     cur_kind;
    alu_op_e       cur_op;
    logic          cur_src, cur_dst;
    logic [AW-1:0] cur_slot;
    logic [W-1:0]  cur_wdata;

    logic [W-1:0]  rd_a [NUM_BANKS];
    logic [W-1:0]  rd_b [NUM_BANKS];
    logic          bank_we [NUM_BANKS];

    logic          wr_en, wr_bank;
    logic [AW-1:0] wr_slot;
    logic [W-1:0]  wr_data;
    logic [W-1:0]  opa, opb, as_res, mul_res;
    logic          mul_start, mul_done, accept;

    assign accept = uop_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_we[g] = wr_en && (wr_bank == 1'(g));
        dbk_bank #(.W(W), .AW(AW)) u_bank (
            .clk(clk), .we(bank_we[g]), .waddr(wr_slot), .wdata(wr_data),
            .raddr_a(src_a), .raddr_b(src_b),
            .rdata_a(rd_a[g]), .rdata_b(rd_b[g])
        );
    end

    assign opa = cur_src ? rd_a[1] : rd_a[0];
    assign opb = cur_src ? rd_b[1] : rd_b[0];

    dbk_addsub #(.W(W), .MODULUS(MODULUS)) u_addsub (
        .a(opa), .b(opb), .sub(cur_op == A_SUB), .r(as_res)
    );

    assign mul_start = (state == ST_EXEC) && (cur_kind == K_CALC) && (cur_op == A_MUL);

    dbk_mulseq #(.W(W), .MODULUS(MODULUS)) u_mul (
        .clk(clk), .rst(rst), .start(mul_start), .a(opa), .b(opb),
        .done(mul_done), .res(mul_res)
    );

    always_comb begin
        wr_en   = 1'b0;
        wr_bank = cur_dst;
        wr_slot = cur_slot;
        wr_data = cur_wdata;
        if (state == ST_EXEC) begin
            case (cur_kind)
                K_LOAD: wr_en = 1'b1;
                K_MOVE: begin
                    wr_en   = 1'b1;
                    wr_data = opa;
                end
                K_CALC: if (cur_op != A_MUL) begin
                    wr_en   = 1'b1;
                    wr_bank = ~cur_src;
                    wr_data = as_res;
                end
                default: ;
            endcase
        end else if (state == ST_MUL && mul_done) begin
            wr_en   = 1'b1;
            wr_bank = ~cur_src;
            wr_data = mul_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cur_kind    <= K_NOP;
            cur_op      <= A_ADD;
            cur_src     <= 1'b0;
            cur_dst     <= 1'b0;
            cur_slot    <= '0;
            cur_wdata   <= '0;
            ext_rdata   <= '0;
            rdata_valid <= 1'b0;
            zero_flag   <= 1'b0;
            err         <= 1'b0;
        end else begin
            err         <= uop_valid && busy;
            rdata_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    state     <= ST_EXEC;
                    cur_kind  <= uop_kind_e'(uop_kind);
                    cur_op    <= alu_op_e'(alu_op);
                    cur_src   <= src_bank;
                    cur_dst   <= dst_bank;
                    cur_slot  <= dst_slot;
                    cur_wdata <= ext_wdata;
                end
                ST_EXEC: begin
                    state <= mul_start ? ST_MUL : ST_IDLE;
                    if (cur_kind == K_STORE) begin
                        ext_rdata   <= opa;
                        rdata_valid <= 1'b1;
                    end
                    if (cur_kind == K_CMPZ)
                        zero_flag <= (opa == '0);
                end
                ST_MUL: if (mul_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbk_checker.sv
module dbk_checker (
    input logic clk,
    input logic rst,
    input logic uop_valid,
    input logic busy,
    input logic err,
    input logic rdata_valid,
    input logic zero_flag
);
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(uop_valid) && $past(busy)));

    p_no_err_on_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !busy) |=> !err);

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !busy) |=> busy);

    p_rdv_single_r8: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(zero_flag));
endmodule

bind dual_bank_datapath dbk_checker u_dbk_checker (
    .clk(clk), .rst(rst), .uop_valid(uop_valid), .busy(busy),
    .err(err), .rdata_valid(rdata_valid), .zero_flag(zero_flag)
);

// File: tb/dual_bank_datapath_bench.sv
`timescale 1ns/1ps
module dual_bank_datapath_bench;
    localparam int P = 251;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uop_valid = 1'b0;
    logic [2:0] uop_kind = '0;
    logic [1:0] alu_op = '0;
    logic       src_bank = 1'b0;
    logic [4:0] src_a = '0, src_b = '0, dst_slot = '0;
    logic       dst_bank = 1'b0;
    logic [7:0] ext_wdata = '0;
    logic [7:0] ext_rdata;
    logic       rdata_valid, busy, zero_flag, err;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    dual_bank_datapath u_dual_bank_datapath (
        .clk(clk), .rst(rst), .uop_valid(uop_valid), .uop_kind(uop_kind),
        .alu_op(alu_op), .src_bank(src_bank), .src_a(src_a), .src_b(src_b),
        .dst_bank(dst_bank), .dst_slot(dst_slot), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .rdata_valid(rdata_valid), .busy(busy),
        .zero_flag(zero_flag), .err(err)
    );

    // {alu op, a, b}
    localparam logic [17:0] VEC [10] = '{
        {2'd0, 8'd200, 8'd100}, {2'd0, 8'd0,   8'd0},
        {2'd0, 8'd250, 8'd1},   {2'd1, 8'd3,   8'd10},
        {2'd1, 8'd10,  8'd3},   {2'd1, 8'd5,   8'd5},
        {2'd2, 8'd250, 8'd250}, {2'd2, 8'd17,  8'd0},
        {2'd2, 8'd123, 8'd45},  {2'd2, 8'd1,   8'd250}
    };

    function automatic int model(input int op, input int a, input int b);
        if (op == 0) return (a + b) % P;
        if (op == 1) return (a + P - b) % P;
        return (a * b) % P;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [1:0] o, input logic sb,
                         input logic [4:0] a, input logic [4:0] b, input logic db,
                         input logic [4:0] ds, input logic [7:0] wd);
        uop_kind = k; alu_op = o; src_bank = sb; src_a = a; src_b = b;
        dst_bank = db; dst_slot = ds; ext_wdata = wd; uop_valid = 1'b1;
        @(negedge clk);
        uop_valid = 1'b0;
        while (busy) begin
            if (rdata_valid) got = ext_rdata;
            @(negedge clk);
        end
        if (rdata_valid) got = ext_rdata;
    endtask

    task automatic load(input logic bk, input logic [4:0] sl, input logic [7:0] v);
        issue(3'd1, 2'd0, 1'b0, 5'd0, 5'd0, bk, sl, v);
    endtask

    task automatic store(input logic bk, input logic [4:0] sl);
        got = 8'hxx;
        issue(3'd2, 2'd0, bk, sl, 5'd0, 1'b0, 5'd0, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy, 0, "R1 busy");
        check(zero_flag, 0, "R1 zero_flag");
        check(err, 0, "R1 err");
        check(rdata_valid, 0, "R1 rdata_valid");

        // vector table: R2 R3 R4 R5 R10
        for (int i = 0; i < 10; i++) begin
            logic s;
            int op, a, b;
            s  = 1'(i % 2);
            op = int'(VEC[i][17:16]);
            a  = int'(VEC[i][15:8]);
            b  = int'(VEC[i][7:0]);
            load(s, 5'd1, VEC[i][15:8]);
            load(s, 5'd2, VEC[i][7:0]);
            load(s, 5'd4, 8'h33);
            load(~s, 5'd4, 8'hA5);
            // dst_bank names the source bank on purpose; it must be ignored
            issue(3'd5, VEC[i][17:16], s, 5'd1, 5'd2, s, 5'd4, 8'd0);
            store(~s, 5'd4);
            check(int'(got), model(op, a, b),
                  op == 0 ? "R3 add" : (op == 1 ? "R4 sub" : "R5 mul"));
            store(s, 5'd4);
            check(int'(got), 8'h33, "R2 source bank untouched");
        end

        // R10 load followed at once by store
        load(1'b0, 5'd31, 8'd201);
        store(1'b0, 5'd31);
        check(int'(got), 201, "R10 write then read");

        // R6 move, R8 store
        load(1'b1, 5'd5, 8'd123);
        issue(3'd3, 2'd0, 1'b1, 5'd5, 5'd0, 1'b0, 5'd7, 8'd0);
        store(1'b0, 5'd7);
        check(int'(got), 123, "R6 move copy");
        store(1'b1, 5'd5);
        check(int'(got), 123, "R8 store source kept");

        // R7 compare
        load(1'b1, 5'd20, 8'd0);
        issue(3'd4, 2'd0, 1'b1, 5'd20, 5'd0, 1'b0, 5'd0, 8'd0);
        check(zero_flag, 1, "R7 zero detected");
        load(1'b0, 5'd21, 8'd9);
        check(zero_flag, 1, "R7 flag held");
        issue(3'd4, 2'd0, 1'b0, 5'd21, 5'd0, 1'b0, 5'd0, 8'd0);
        check(zero_flag, 0, "R7 nonzero");

        // R9 issue while busy
        load(1'b0, 5'd9, 8'd11);
        load(1'b0, 5'd10, 8'd5);
        load(1'b0, 5'd11, 8'd6);
        uop_kind = 3'd5; alu_op = 2'd2; src_bank = 1'b0; src_a = 5'd10;
        src_b = 5'd11; dst_bank = 1'b0; dst_slot = 5'd12; uop_valid = 1'b1;
        @(negedge clk);
        check(busy, 1, "R5 busy during multiply");
        uop_kind = 3'd1; dst_bank = 1'b0; dst_slot = 5'd9; ext_wdata = 8'd55;
        @(negedge clk);
        uop_valid = 1'b0;
        check(err, 1, "R9 err pulse");
        while (busy) @(negedge clk);
        check(err, 0, "R9 err one cycle");
        store(1'b0, 5'd9);
        check(int'(got), 11, "R9 busy issue ignored");
        store(1'b1, 5'd12);
        check(int'(got), 30, "R5 product after busy");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule